// File: doc/BRIEF.md
# Single-Cycle Pulse Stretcher

This block widens a one-clock trigger into a clean, registered output pulse that stays high for a fixed number of clock cycles, four unless the length parameter is changed. Control logic uses it wherever a one-cycle event has to be visible to slower logic for several cycles, for example an enable or a strobe that has to be sampled more than once.

Two internal structures can be chosen at elaboration time, and they produce the same waveform. The delay-line variant keeps an output flip-flop that the trigger sets through its clock enable with the data held high. A copy of the trigger, delayed through a shift register whose depth equals the pulse length, clears that flip-flop. The counter variant loads a small down-counter on the trigger, and the counter's top bit is both the output and the count enable. In both variants the output comes straight from a flop, so it cannot glitch. A trigger that arrives while the output is high is dropped, so a pulse is never extended. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `pulse_widener`

## Requirements
- R1: While rst_n is low, pulse_o is low. After reset is released, pulse_o stays low until a trigger is accepted.
- R2: A trigger accepted in cycle t, meaning trig_i is high while pulse_o is low, makes pulse_o high in cycles t+1 through t+LEN and low in cycle t+LEN+1. With the default LEN=4 this is exactly four cycles.
- R3: pulse_o rises only in the cycle right after a cycle in which trig_i was high.
- R4: A trigger in any cycle in which pulse_o is already high has no effect: the pulse still ends LEN cycles after its own trigger.
- R5: A trigger in the first cycle after pulse_o falls starts a new pulse of the full LEN cycles. A trigger held high continuously gives LEN cycles high and one cycle low, repeating.
- R6: With IMPL=PW_DELAY, the output flop is set by the accepted trigger and cleared by that trigger delayed through a LEN-stage shift line. At most one trigger is in flight in that line.
- R7: With IMPL=PW_COUNT, a counter of $clog2(LEN)+1 bits is loaded with 2^(W-1)+LEN-1 on an accepted trigger. It counts down by one while its top bit is high, and that top bit drives pulse_o.
- R8: For the same LEN and the same trig_i sequence, both values of IMPL give identical pulse_o waveforms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_i | input | 1 | Trigger; a high cycle requests a pulse |
| pulse_o | output | 1 | Stretched pulse, driven directly by a flop |

## Verification
The assertions assume that trig_i is synchronous to clk and is a clean level at each rising edge. They also assume that nothing inside the block is reset in the middle of a cycle except through rst_n. The bench therefore changes trig_i only on falling edges, and it waits out the reset synchronizer before it sends the first trigger. Triggers are sent as isolated pulses, as triggers that land while the output is high, as a held level, and as a pseudo-random stream. All four bench instances (two lengths, two structures) are driven from the same trig_i, so the checks in R8 compare them cycle by cycle.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic {
    PW_DELAY = 1'b0,
    PW_COUNT = 1'b1
  } impl_e;

  // Counter width that gives the top bit room to stay high for n cycles.
  function automatic int cnt_width(input int n);
    return $clog2(n) + 1;
  endfunction

endpackage

// File: rtl/pw_rst_sync.sv
module pw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pw_delay_line.sv
module pw_delay_line #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  logic [LEN-1:0] line_q, line_d;
  logic           out_q, out_d, out_en;
  logic           accept, clear;

  always_comb begin
    accept = trig_i & ~out_q;
    clear  = line_q[LEN-1];
    line_d = {line_q[LEN-2:0], accept};
    // Set/clear flop: enable on either event, clear wins, data high for set.
    out_en = accept | clear;
    out_d  = ~clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= 1'b0;
    else if (out_en) out_q <= out_d;
  end

  assign pulse_o = out_q;

  // R2: an accepted trigger sets the output on the next edge
  a_r2_set_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_q);
  // R6: the delayed copy leaving the line clears the output
  a_r6_clear_from_line: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !out_q);
  // R6: only one trigger travels the line at a time
  a_r6_single_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(line_q) <= 1);
  // R3: a rise needs a trigger in the cycle before
  a_r3_rise_from_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(trig_i));
endmodule

// File: rtl/pw_down_counter.sv
module pw_down_counter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int           W    = pw_pkg::cnt_width(LEN);
  localparam logic [W-1:0] LOAD = W'((2 ** (W - 1)) + LEN - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en, accept, busy;

  always_comb begin
    busy   = cnt_q[W-1];
    accept = trig_i & ~busy;
    cnt_en = accept | busy;
    cnt_d  = accept ? LOAD : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_o = busy;

  // R7: accepted trigger loads the start value
  a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cnt_q == LOAD));
  // R7: while the top bit is high the counter steps down by one
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> (cnt_q == $past(cnt_q) - W'(1)));
  // R4: a trigger while busy does not reload
  a_r4_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_i) |=> (cnt_q != LOAD));
  // R3: a rise needs a trigger in the cycle before
  a_r3_rise_from_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_i));
endmodule

// File: rtl/pulse_widener.sv
module pulse_widener #(
  parameter int            LEN  = 4,
  parameter pw_pkg::impl_e IMPL = pw_pkg::PW_DELAY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  logic rst_sync_n;

  pw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  generate
    if (IMPL == pw_pkg::PW_DELAY) begin : g_delay
      pw_delay_line #(.LEN(LEN)) u_core (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .trig_i  (trig_i),
        .pulse_o (pulse_o)
      );
    end else begin : g_count
      pw_down_counter #(.LEN(LEN)) u_core (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .trig_i  (trig_i),
        .pulse_o (pulse_o)
      );
    end
  endgenerate

  // R1: output is low while the raw reset is asserted
  a_r1_low_in_reset: assert property (@(posedge clk)
    !rst_n |-> !pulse_o);
endmodule

// File: tb/sim_pulse_widener.sv
`timescale 1ns/1ps
module sim_pulse_widener;
  localparam int LA = 4;
  localparam int LB = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic p0, p1, p2, p3;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_widener #(.LEN(LA), .IMPL(pw_pkg::PW_DELAY)) u0 (.clk(clk), .rst_n(rst_n), .trig_i(trig), .pulse_o(p0));
  pulse_widener #(.LEN(LA), .IMPL(pw_pkg::PW_COUNT)) u1 (.clk(clk), .rst_n(rst_n), .trig_i(trig), .pulse_o(p1));
  pulse_widener #(.LEN(LB), .IMPL(pw_pkg::PW_DELAY)) u2 (.clk(clk), .rst_n(rst_n), .trig_i(trig), .pulse_o(p2));
  pulse_widener #(.LEN(LB), .IMPL(pw_pkg::PW_COUNT)) u3 (.clk(clk), .rst_n(rst_n), .trig_i(trig), .pulse_o(p3));

  // Behavioural model: remaining high cycles for each length.
  logic [4:0] rem_a, rem_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_a <= '0;
      rem_b <= '0;
    end else begin
      rem_a <= (rem_a == 0) ? (trig ? 5'(LA) : 5'd0) : rem_a - 5'd1;
      rem_b <= (rem_b == 0) ? (trig ? 5'(LB) : 5'd0) : rem_b - 5'd1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R6 delay LEN4"}, p0, rem_a != 0);
    chk({tag, " R7 count LEN4"}, p1, rem_a != 0);
    chk({tag, " R6 delay LEN7"}, p2, rem_b != 0);
    chk({tag, " R7 count LEN7"}, p3, rem_b != 0);
    chk({tag, " R8 match LEN4"}, p1, p0);
    chk({tag, " R8 match LEN7"}, p3, p2);
  endtask

  // Drive trig for one cycle, then check at the following falling edge.
  task automatic step(input logic t, input string tag);
    trig = t;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    trig = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset u0", p0, 1'b0);
    chk("R1 in reset u1", p1, 1'b0);
    rst_n = 1'b1;
    idle(8, "R1 idle after reset");
  endtask

  task automatic t_single();
    int highs = 0;
    step(1'b1, "R3 trigger edge");
    chk("R3 rise one cycle after trigger", p0, 1'b1);
    highs = 1;
    for (int i = 0; i < 10; i++) begin
      step(1'b0, "R2 single pulse");
      if (p0) highs++;
    end
    chk("R2 width equals four", (highs == LA), 1'b1);
  endtask

  task automatic t_ignored();
    step(1'b1, "R4 first trigger");
    step(1'b0, "R4 gap");
    step(1'b1, "R4 trigger while high");
    step(1'b1, "R4 trigger while high");
    chk("R4 last high cycle u0", p0, 1'b1);
    step(1'b0, "R4 pulse not extended");
    chk("R4 ended on time u0", p0, 1'b0);
    idle(8, "R4 tail");
  endtask

  task automatic t_retrigger();
    step(1'b1, "R5 first");
    idle(LA - 1, "R5 high");
    step(1'b0, "R5 fall");
    chk("R5 low after fall u0", p0, 1'b0);
    step(1'b1, "R5 trigger right after fall");
    chk("R5 new pulse u0", p0, 1'b1);
    idle(10, "R5 second pulse");
    for (int i = 0; i < 24; i++) step(1'b1, "R5 held trigger");
    idle(10, "R5 drain");
  endtask

  task automatic t_random();
    logic [31:0] lfsr = 32'h1D2C_3B4A;
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      step(lfsr[31:30] == 2'b00, "R8 random");
    end
    idle(10, "R8 random drain");
  endtask

  task automatic t_reset_mid();
    step(1'b1, "R1 mid trigger");
    step(1'b0, "R1 mid high");
    rst_n = 1'b0;
    #1;
    chk("R1 async clear u0", p0, 1'b0);
    chk("R1 async clear u3", p3, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(6, "R1 after mid reset");
  endtask

  initial begin
    t_reset();
    t_single();
    t_ignored();
    t_retrigger();
    t_random();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule